// File: doc/BRIEF.md
# Registered Bus Transceiver Lane with Parity Generation and Checking

This block is one lane of a registered, bidirectional bus transceiver. Each of its two ports, A and B, carries an eight-bit data field and a single parity bit. Each port has a capture register that loads that port's incoming data on a rising clock edge when its capture enable is high. A port that drives its bus always drives the contents of the opposite port's register, so data crosses the lane with one register stage.

Three control inputs select the lane mode: a hold-off input per port (`a_off`, `b_off`) and a parity-disable input (`par_dis`). A held-off port treats its pins as inputs. A port that is not held off drives its bus. With parity enabled, the driving side also drives a generated parity bit. The receiving side has its parity checked, and its active-low error flag is driven. With parity disabled, the lane is a plain registered transceiver. An odd/even select (`odd_sel`) sets the parity sense for generation and checking alike.

Tri-state pads are represented by a separate output-enable bit next to each output value. The mode decoder is a combinational state selector with eight named states:
- CHK_A_GEN_B: `par_dis`=0, `a_off`=1, `b_off`=0.
- CHK_B_GEN_A: 0, 0, 1.
- CHK_BOTH: 0, 1, 1.
- GEN_BOTH: 0, 0, 0.
- PASS_AB: 1, 1, 0.
- PASS_BA: 1, 0, 1.
- ISOLATE: 1, 1, 1.
- PASS_BOTH: 1, 0, 0.

The lane moves between any two states in the same cycle that the control inputs change. There is no intermediate state.

Top module: `xpar_lane`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears both capture registers to zero. After reset, a port that drives its bus drives 0x00.
- R2: The A register loads `a_din` only on a rising edge with `cap_a` high, and the B register loads `b_din` only on a rising edge with `cap_b` high. Otherwise each register keeps its value, and a driving port shows the new value only after the capturing edge.
- R3: In CHK_A_GEN_B, port B drives the stored A data with its data enable and parity enable high. Port A drives no data and no parity, and its error enable is high. Port B's error enable is low.
- R4: In CHK_B_GEN_A, port A drives the stored B data with its data enable and parity enable high. Port B drives no data and no parity, and its error enable is high. Port A's error enable is low.
- R5: In CHK_BOTH, no data enable and no parity enable is high, and both error enables are high.
- R6: In GEN_BOTH, port A drives the stored B data and port B drives the stored A data. Both parity enables are high and both error enables are low.
- R7: A generated parity bit makes the number of ones among the eight driven data bits plus the parity bit even when `odd_sel`=0 and odd when `odd_sel`=1. It follows a register change on the first edge after that change.
- R8: A driven error flag is 1 when the number of ones among that port's eight input data bits plus its input parity bit is even with `odd_sel`=0, or odd with `odd_sel`=1, and 0 otherwise. It is combinational from the current inputs and valid in the same cycle.
- R9: In PASS_AB, PASS_BA and PASS_BOTH, every port that is not held off drives the stored data of the opposite port. All parity enables and error enables are low.
- R10: In ISOLATE, every output enable is low.
- R11: Every output value whose enable is low is held at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| cap_a | input | 1 | Load `a_din` into the A register |
| cap_b | input | 1 | Load `b_din` into the B register |
| a_off | input | 1 | Port A held off (pins are inputs) |
| b_off | input | 1 | Port B held off (pins are inputs) |
| par_dis | input | 1 | Parity functions disabled |
| odd_sel | input | 1 | 1 = odd parity sense, 0 = even |
| a_din | input | 8 | Port A data pins, input side |
| a_par_in | input | 1 | Port A parity pin, input side |
| b_din | input | 8 | Port B data pins, input side |
| b_par_in | input | 1 | Port B parity pin, input side |
| a_dout | output | 8 | Port A data pins, output value |
| a_dout_oe | output | 1 | Port A data output enable |
| a_par_out | output | 1 | Port A parity output value |
| a_par_oe | output | 1 | Port A parity output enable |
| a_err_n | output | 1 | Port A parity error flag, active low |
| a_err_oe | output | 1 | Port A error flag enable |
| b_dout | output | 8 | Port B data pins, output value |
| b_dout_oe | output | 1 | Port B data output enable |
| b_par_out | output | 1 | Port B parity output value |
| b_par_oe | output | 1 | Port B parity output enable |
| b_err_n | output | 1 | Port B parity error flag, active low |
| b_err_oe | output | 1 | Port B error flag enable |

## Verification
In CHK_A_GEN_B, two things can happen in one cycle. Port A's error flag judges the bus arriving at A in the current cycle, while the A register captures that same word and changes the parity generated on B at the next edge. The bench holds this mode and walks all 256 data values with `cap_a` high. Before the edge, it checks the error flag against the incoming word and checks that port B still shows the previous word. After the edge, it checks that B shows the new word with a parity bit of the selected sense. An exhaustive checker sweep and a sweep over every mode and both parity senses, each with several register contents, cover the rest.

// File: rtl/xpar_pkg.sv
package xpar_pkg;

    localparam int unsigned DATA_W = 8;
    localparam int unsigned SIDES  = 2;
    localparam int unsigned SIDE_A = 0;
    localparam int unsigned SIDE_B = 1;

    // Lane mode, decoded from {par_dis, a_off, b_off}
    typedef enum logic [2:0] {
        M_GEN_BOTH    = 3'b000,
        M_CHK_B_GEN_A = 3'b001,
        M_CHK_A_GEN_B = 3'b010,
        M_CHK_BOTH    = 3'b011,
        M_PASS_BOTH   = 3'b100,
        M_PASS_BA     = 3'b101,
        M_PASS_AB     = 3'b110,
        M_ISOLATE     = 3'b111
    } lane_mode_e;

    // Per-port behaviour selected by the mode
    typedef struct packed {
        logic drive;   // bus pins driven from the opposite register
        logic gen;     // parity pin driven with generated parity
        logic check;   // incoming bus checked, error flag driven
    } side_ctl_t;

    localparam side_ctl_t CTL_IDLE = '{drive: 1'b0, gen: 1'b0, check: 1'b0};

endpackage

// File: rtl/xpar_mode_dec.sv
module xpar_mode_dec
    import xpar_pkg::*;
(
    input  logic       par_dis,
    input  logic       a_off,
    input  logic       b_off,
    output lane_mode_e mode,
    output side_ctl_t  ctl_a,
    output side_ctl_t  ctl_b
);

    // State selection
    always_comb begin
        unique case ({par_dis, a_off, b_off})
            3'b000:  mode = M_GEN_BOTH;
            3'b001:  mode = M_CHK_B_GEN_A;
            3'b010:  mode = M_CHK_A_GEN_B;
            3'b011:  mode = M_CHK_BOTH;
            3'b100:  mode = M_PASS_BOTH;
            3'b101:  mode = M_PASS_BA;
            3'b110:  mode = M_PASS_AB;
            default: mode = M_ISOLATE;
        endcase
    end

    // Per-state outputs
    always_comb begin
        ctl_a = CTL_IDLE;
        ctl_b = CTL_IDLE;
        unique case (mode)
            M_GEN_BOTH: begin
                ctl_a = '{drive: 1'b1, gen: 1'b1, check: 1'b0};
                ctl_b = '{drive: 1'b1, gen: 1'b1, check: 1'b0};
            end
            M_CHK_B_GEN_A: begin
                ctl_a = '{drive: 1'b1, gen: 1'b1, check: 1'b0};
                ctl_b = '{drive: 1'b0, gen: 1'b0, check: 1'b1};
            end
            M_CHK_A_GEN_B: begin
                ctl_a = '{drive: 1'b0, gen: 1'b0, check: 1'b1};
                ctl_b = '{drive: 1'b1, gen: 1'b1, check: 1'b0};
            end
            M_CHK_BOTH: begin
                ctl_a = '{drive: 1'b0, gen: 1'b0, check: 1'b1};
                ctl_b = '{drive: 1'b0, gen: 1'b0, check: 1'b1};
            end
            M_PASS_BOTH: begin
                ctl_a = '{drive: 1'b1, gen: 1'b0, check: 1'b0};
                ctl_b = '{drive: 1'b1, gen: 1'b0, check: 1'b0};
            end
            M_PASS_BA: begin
                ctl_a = '{drive: 1'b1, gen: 1'b0, check: 1'b0};
            end
            M_PASS_AB: begin
                ctl_b = '{drive: 1'b1, gen: 1'b0, check: 1'b0};
            end
            M_ISOLATE: begin
                ctl_a = CTL_IDLE;
                ctl_b = CTL_IDLE;
            end
            default: begin
                ctl_a = CTL_IDLE;
                ctl_b = CTL_IDLE;
            end
        endcase
    end

endmodule

// File: rtl/xpar_store.sv
module xpar_store #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cap_a,
    input  logic         cap_b,
    input  logic [W-1:0] din_a,
    input  logic [W-1:0] din_b,
    output logic [W-1:0] q_a,
    output logic [W-1:0] q_b
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q_a <= '0;
            q_b <= '0;
        end else begin
            if (cap_a) q_a <= din_a;
            if (cap_b) q_b <= din_b;
        end
    end

endmodule

// File: rtl/xpar_side.sv
module xpar_side
    import xpar_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  side_ctl_t    ctl,
    input  logic         odd_sel,
    input  logic [W-1:0] src,
    input  logic [W-1:0] din,
    input  logic         par_in,
    output logic [W-1:0] dout,
    output logic         dout_oe,
    output logic         par_out,
    output logic         par_oe,
    output logic         err_n,
    output logic         err_oe
);

    logic gen_bit;
    logic sum_ok;

    // Generated bit completes the chosen sense over the driven word
    assign gen_bit = (^src) ^ odd_sel;
    // Received word plus parity must carry the chosen sense
    assign sum_ok  = ((^din) ^ par_in) == odd_sel;

    always_comb begin
        dout    = ctl.drive ? src : '0;
        dout_oe = ctl.drive;
        par_out = ctl.gen ? gen_bit : 1'b0;
        par_oe  = ctl.gen;
        err_n   = ctl.check ? sum_ok : 1'b0;
        err_oe  = ctl.check;
    end

endmodule

// File: rtl/xpar_lane.sv
module xpar_lane
    import xpar_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cap_a,
    input  logic         cap_b,
    input  logic         a_off,
    input  logic         b_off,
    input  logic         par_dis,
    input  logic         odd_sel,
    input  logic [W-1:0] a_din,
    input  logic         a_par_in,
    input  logic [W-1:0] b_din,
    input  logic         b_par_in,
    output logic [W-1:0] a_dout,
    output logic         a_dout_oe,
    output logic         a_par_out,
    output logic         a_par_oe,
    output logic         a_err_n,
    output logic         a_err_oe,
    output logic [W-1:0] b_dout,
    output logic         b_dout_oe,
    output logic         b_par_out,
    output logic         b_par_oe,
    output logic         b_err_n,
    output logic         b_err_oe
);

    logic [W-1:0] q_a;
    logic [W-1:0] q_b;
    lane_mode_e   mode;
    side_ctl_t    ctl [SIDES];

    logic [W-1:0] s_src  [SIDES];
    logic [W-1:0] s_din  [SIDES];
    logic         s_pin  [SIDES];
    logic [W-1:0] s_dout [SIDES];
    logic         s_doe  [SIDES];
    logic         s_pout [SIDES];
    logic         s_poe  [SIDES];
    logic         s_errn [SIDES];
    logic         s_eoe  [SIDES];

    xpar_store #(.W(W)) u_store (
        .clk   (clk),
        .rst   (rst),
        .cap_a (cap_a),
        .cap_b (cap_b),
        .din_a (a_din),
        .din_b (b_din),
        .q_a   (q_a),
        .q_b   (q_b)
    );

    xpar_mode_dec u_dec (
        .par_dis (par_dis),
        .a_off   (a_off),
        .b_off   (b_off),
        .mode    (mode),
        .ctl_a   (ctl[SIDE_A]),
        .ctl_b   (ctl[SIDE_B])
    );

    // Each port drives the word held for the opposite port
    assign s_src[SIDE_A] = q_b;
    assign s_src[SIDE_B] = q_a;
    assign s_din[SIDE_A] = a_din;
    assign s_din[SIDE_B] = b_din;
    assign s_pin[SIDE_A] = a_par_in;
    assign s_pin[SIDE_B] = b_par_in;

    for (genvar s = 0; s < SIDES; s++) begin : g_side
        xpar_side #(.W(W)) u_side (
            .ctl     (ctl[s]),
            .odd_sel (odd_sel),
            .src     (s_src[s]),
            .din     (s_din[s]),
            .par_in  (s_pin[s]),
            .dout    (s_dout[s]),
            .dout_oe (s_doe[s]),
            .par_out (s_pout[s]),
            .par_oe  (s_poe[s]),
            .err_n   (s_errn[s]),
            .err_oe  (s_eoe[s])
        );
    end

    assign a_dout    = s_dout[SIDE_A];
    assign a_dout_oe = s_doe[SIDE_A];
    assign a_par_out = s_pout[SIDE_A];
    assign a_par_oe  = s_poe[SIDE_A];
    assign a_err_n   = s_errn[SIDE_A];
    assign a_err_oe  = s_eoe[SIDE_A];
    assign b_dout    = s_dout[SIDE_B];
    assign b_dout_oe = s_doe[SIDE_B];
    assign b_par_out = s_pout[SIDE_B];
    assign b_par_oe  = s_poe[SIDE_B];
    assign b_err_n   = s_errn[SIDE_B];
    assign b_err_oe  = s_eoe[SIDE_B];

endmodule

// File: rtl/xpar_lane_chk.sv
module xpar_lane_chk #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         cap_a,
    input logic         par_dis,
    input logic         a_off,
    input logic         b_off,
    input logic         odd_sel,
    input logic [W-1:0] q_a,
    input logic [W-1:0] q_b,
    input logic [W-1:0] a_dout,
    input logic         a_dout_oe,
    input logic         a_par_out,
    input logic         a_par_oe,
    input logic         a_err_oe,
    input logic [W-1:0] b_dout,
    input logic         b_dout_oe,
    input logic         b_par_out,
    input logic         b_par_oe,
    input logic         b_err_oe
);

    p_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (q_a == '0 && q_b == '0));

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !cap_a |=> $stable(q_a));

    p_dir_r3: assert property (@(posedge clk) disable iff (rst)
        (!par_dis && a_off && !b_off) |->
            (b_dout_oe && b_par_oe && !a_dout_oe && !a_par_oe && a_err_oe && !b_err_oe));

    p_dir_r4: assert property (@(posedge clk) disable iff (rst)
        (!par_dis && !a_off && b_off) |->
            (a_dout_oe && a_par_oe && !b_dout_oe && !b_par_oe && b_err_oe && !a_err_oe));

    p_chk_both_r5: assert property (@(posedge clk) disable iff (rst)
        (!par_dis && a_off && b_off) |->
            (!a_dout_oe && !b_dout_oe && !a_par_oe && !b_par_oe && a_err_oe && b_err_oe));

    p_cross_r6: assert property (@(posedge clk) disable iff (rst)
        (a_dout_oe && b_dout_oe) |-> (a_dout == q_b && b_dout == q_a));

    p_gen_a_r7: assert property (@(posedge clk) disable iff (rst)
        a_par_oe |-> (((^a_dout) ^ a_par_out) == odd_sel));

    p_gen_b_r7: assert property (@(posedge clk) disable iff (rst)
        b_par_oe |-> (((^b_dout) ^ b_par_out) == odd_sel));

    p_err_gate_r8: assert property (@(posedge clk) disable iff (rst)
        (a_err_oe || b_err_oe) |-> !par_dis);

    p_no_parity_r9: assert property (@(posedge clk) disable iff (rst)
        par_dis |-> (!a_par_oe && !b_par_oe && !a_err_oe && !b_err_oe));

    p_isolate_r10: assert property (@(posedge clk) disable iff (rst)
        (par_dis && a_off && b_off) |-> (!a_dout_oe && !b_dout_oe));

endmodule

bind xpar_lane xpar_lane_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cap_a     (cap_a),
    .par_dis   (par_dis),
    .a_off     (a_off),
    .b_off     (b_off),
    .odd_sel   (odd_sel),
    .q_a       (q_a),
    .q_b       (q_b),
    .a_dout    (a_dout),
    .a_dout_oe (a_dout_oe),
    .a_par_out (a_par_out),
    .a_par_oe  (a_par_oe),
    .a_err_oe  (a_err_oe),
    .b_dout    (b_dout),
    .b_dout_oe (b_dout_oe),
    .b_par_out (b_par_out),
    .b_par_oe  (b_par_oe),
    .b_err_oe  (b_err_oe)
);

// File: tb/xpar_lane_bench.sv
module xpar_lane_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cap_a = 1'b0, cap_b = 1'b0;
    logic       a_off = 1'b1, b_off = 1'b1, par_dis = 1'b1, odd_sel = 1'b0;
    logic [7:0] a_din = '0, b_din = '0;
    logic       a_par_in = 1'b0, b_par_in = 1'b0;
    logic [7:0] a_dout, b_dout;
    logic       a_dout_oe, a_par_out, a_par_oe, a_err_n, a_err_oe;
    logic       b_dout_oe, b_par_out, b_par_oe, b_err_n, b_err_oe;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [7:0] ra_m = '0, rb_m = '0;

    always #2 clk = ~clk;

    xpar_lane u_xpar_lane (
        .clk(clk), .rst(rst), .cap_a(cap_a), .cap_b(cap_b),
        .a_off(a_off), .b_off(b_off), .par_dis(par_dis), .odd_sel(odd_sel),
        .a_din(a_din), .a_par_in(a_par_in), .b_din(b_din), .b_par_in(b_par_in),
        .a_dout(a_dout), .a_dout_oe(a_dout_oe), .a_par_out(a_par_out),
        .a_par_oe(a_par_oe), .a_err_n(a_err_n), .a_err_oe(a_err_oe),
        .b_dout(b_dout), .b_dout_oe(b_dout_oe), .b_par_out(b_par_out),
        .b_par_oe(b_par_oe), .b_err_n(b_err_n), .b_err_oe(b_err_oe)
    );

    // {dout, dout_oe, par_out, par_oe, err_n, err_oe} for one port
    function automatic logic [12:0] side_exp(input logic pd, input logic off,
            input logic odd, input logic [7:0] src, input logic [7:0] din,
            input logic pin);
        logic drv, gen, chk, pbit, ok;
        int   cs, cd;
        drv  = !off;
        gen  = drv && !pd;
        chk  = off && !pd;
        cs   = $countones(src);
        cd   = $countones(din) + int'(pin);
        pbit = ((cs % 2) == 1) ^ odd;
        ok   = ((cd % 2) == 1) == odd;
        return {drv ? src : 8'h00, drv, gen ? pbit : 1'b0, gen, chk ? ok : 1'b0, chk};
    endfunction

    function automatic logic [25:0] actual();
        return {a_dout, a_dout_oe, a_par_out, a_par_oe, a_err_n, a_err_oe,
                b_dout, b_dout_oe, b_par_out, b_par_oe, b_err_n, b_err_oe};
    endfunction

    function automatic logic [25:0] lane_exp();
        return {side_exp(par_dis, a_off, odd_sel, rb_m, a_din, a_par_in),
                side_exp(par_dis, b_off, odd_sel, ra_m, b_din, b_par_in)};
    endfunction

    function automatic string mode_req(input logic [2:0] m);
        case (m)
            3'b010:  return "R3";
            3'b001:  return "R4";
            3'b011:  return "R5";
            3'b000:  return "R6";
            3'b111:  return "R10";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input string req, input logic [25:0] act, input logic [25:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    task automatic load(input logic [7:0] va, input logic [7:0] vb);
        @(negedge clk);
        a_din = va; b_din = vb; cap_a = 1'b1; cap_b = 1'b1;
        @(negedge clk);
        cap_a = 1'b0; cap_b = 1'b0;
        ra_m = va; rb_m = vb;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        // R1: reset clears both registers
        a_din = 8'hFF; b_din = 8'hFF; cap_a = 1'b1; cap_b = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0; cap_a = 1'b0; cap_b = 1'b0;
        {par_dis, a_off, b_off} = 3'b100;
        #1;
        check("R1", actual(), lane_exp());

        // R2: capture only with enable; value appears after the edge
        load(8'h5A, 8'hC3);
        {par_dis, a_off, b_off} = 3'b100;
        #1;
        check("R2", actual(), lane_exp());
        @(negedge clk);
        a_din = 8'h0F; b_din = 8'hF0;
        @(negedge clk);
        #1;
        check("R2", actual(), lane_exp());

        // R3..R6, R9, R10: every mode, both senses, several stored words
        for (int p = 0; p < 6; p++) begin
            load(8'(8'hA5 ^ (p * 37)), 8'(8'h3C ^ (p * 91)));
            for (int m = 0; m < 8; m++) begin
                for (int o = 0; o < 2; o++) begin
                    @(negedge clk);
                    {par_dis, a_off, b_off} = 3'(m);
                    odd_sel  = 1'(o);
                    a_din    = 8'(p * 53 + m);
                    b_din    = 8'(p * 29 + m * 7);
                    a_par_in = 1'(m);
                    b_par_in = 1'(p + o);
                    #1;
                    check(mode_req(3'(m)), actual(), lane_exp());
                end
            end
        end

        // R11: isolated lane with all inputs high holds every output at 0
        @(negedge clk);
        {par_dis, a_off, b_off} = 3'b111;
        a_din = 8'hFF; b_din = 8'hFF; a_par_in = 1'b1; b_par_in = 1'b1;
        #1;
        check("R11", actual(), 26'd0);

        // R8: exhaustive checker sweep in CHK_BOTH
        {par_dis, a_off, b_off} = 3'b011;
        for (int d = 0; d < 256; d++) begin
            for (int pb = 0; pb < 2; pb++) begin
                for (int o = 0; o < 2; o++) begin
                    a_din = 8'(d); b_din = ~8'(d);
                    a_par_in = 1'(pb); b_par_in = 1'(pb ^ o);
                    odd_sel = 1'(o);
                    #1;
                    check("R8", actual(), lane_exp());
                end
            end
        end

        // R7 with R8/R2 in the same cycle: capture on A while A is checked
        @(negedge clk);
        {par_dis, a_off, b_off} = 3'b010;
        for (int v = 0; v < 256; v++) begin
            odd_sel  = 1'(v >> 1);
            a_din    = 8'(v);
            a_par_in = 1'(v >> 3);
            cap_a    = 1'b1;
            #1;
            check("R8", actual(), lane_exp());
            @(negedge clk);
            cap_a = 1'b0;
            ra_m  = 8'(v);
            #1;
            check("R7", actual(), lane_exp());
        end

        // R7 on port A via GEN_BOTH
        for (int v = 0; v < 16; v++) begin
            load(8'(v * 13), 8'(v * 71 + 5));
            {par_dis, a_off, b_off} = 3'b000;
            odd_sel = 1'(v);
            #1;
            check("R7", actual(), lane_exp());
        end

        finish_run();
    end

endmodule